// File: doc/BRIEF.md
# Power-of-Two Address Window Decoder

The block holds eight programmable address windows. Each window maps part of the host address space onto one of a card's spaces: common memory, attribute memory, I/O, or one of the DMA variants. Every window has a 32-bit base word and a 32-bit option word. The option word carries the following:

- the window size, as a Gray-coded power of two;
- the space type;
- the port width;
- the slot choice;
- a write-protect flag;
- a valid flag;
- three strobe timing values.

Software programs the windows through a simple write port.

On each host access, the decoder compares the address with every valid window. The lowest-numbered window that matches is selected. One cycle later the block presents the following:

- the chosen window index;
- the card address, which is the low 26 host bits used directly with no offset added;
- the space, width and slot of that window;
- the window's strobe timing.

A miss raises a no-hit flag. A write that lands in a protected window raises an error and withholds the access enable. The decoder does not generate bus cycles or card strobes.

Top module: `win_decoder`

## Requirements
- R1: After synchronous reset, every window's base and option words are zero, so no window is valid. All response outputs are zero.
- R2: The response appears on the clock edge that follows an access request, and `rsp_valid` is high for exactly those cycles. When there is no request, `rsp_valid` is low.
- R3: Option bits 31:27 hold a reflected Gray code of the size exponent n, giving a window of 2^n bytes. For example, code 0 is n=0, code 6 is n=4, code 10 is n=12 and code 24 is n=16. A window matches when the host address and the base agree on every bit from bit n upward.
- R4: A window whose option bit 0 (valid) is 0 never matches, whatever its base and size.
- R5: When several valid windows match, the response names the lowest window index.
- R6: When no valid window matches a request, `rsp_miss` is 1. In that case `rsp_hit`, `rsp_en` and `rsp_prot_err` are 0, and the index, card address, attribute and timing outputs are all 0.
- R7: On a hit, `rsp_card_addr` equals host address bits 25:0.
- R8: On a hit, the response carries the winning window's option fields. These are: the space type from bits 5:3 (0 common, 2 attribute, 3 I/O, 4 DMA, 5 DMA last, 6 high-address drive), the width from bit 6 (1 = 16-bit), slot B from bit 2, setup from bits 15:12, strobe length from bits 11:7 and hold from bits 19:16.
- R9: A write that hits a window whose option bit 1 is set gives `rsp_prot_err`=1 and `rsp_en`=0. A read of that window gives `rsp_en`=1 and no error.
- R10: A configuration write takes effect on the next clock edge. An access issued in the same cycle as the write is decoded with the window's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_is_opt | input | 1 | 1 writes the option word, 0 writes the base word |
| cfg_idx | input | 3 | Window being written |
| cfg_wdata | input | 32 | Word to write |
| acc_req | input | 1 | Host access present this cycle |
| acc_wr | input | 1 | Access is a write |
| acc_addr | input | 32 | Host address |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | A valid window matched |
| rsp_miss | output | 1 | No valid window matched |
| rsp_en | output | 1 | Access may proceed |
| rsp_prot_err | output | 1 | Write to a protected window |
| rsp_win | output | 3 | Index of the winning window |
| rsp_card_addr | output | 26 | Card-side address |
| rsp_space | output | 3 | Space type of the window |
| rsp_wide | output | 1 | 16-bit port when 1 |
| rsp_slot_b | output | 1 | Slot B selected |
| rsp_setup | output | 4 | Strobe setup time |
| rsp_len | output | 5 | Strobe length |
| rsp_hold | output | 4 | Strobe hold time |

## Verification
A window can be reprogrammed in the same cycle that a host access targets it. This is what happens when software clears the valid bit to retarget a window while traffic is still flowing.

The bench provokes this case with one falling-edge drive. That drive sets both `cfg_we` (clearing window 3's valid bit) and `acc_req` (an address inside window 3). The response one edge later must still report a hit on window 3. A second access on the next cycle must then report a miss.

Protection checking and window priority also meet in single cycles: a protected window is written in the area where it overlaps no other window, and the table of vectors checks both outcomes together.

// File: rtl/win_pkg.sv
package win_pkg;

    localparam int ADDR_W  = 32;
    localparam int CARD_W  = 26;
    localparam int EXP_W   = 5;

    // option word field positions (behavioural: decoded by this block)
    localparam int OPT_VALID = 0;
    localparam int OPT_WP    = 1;
    localparam int OPT_SLOTB = 2;
    localparam int OPT_SP_LO = 3;
    localparam int OPT_WIDE  = 6;
    localparam int OPT_LN_LO = 7;
    localparam int OPT_SU_LO = 12;
    localparam int OPT_HD_LO = 16;
    localparam int OPT_EX_LO = 27;

    typedef enum logic [2:0] {
        SP_COMMON  = 3'd0,
        SP_RSVD1   = 3'd1,
        SP_ATTR    = 3'd2,
        SP_IO      = 3'd3,
        SP_DMA     = 3'd4,
        SP_DMALAST = 3'd5,
        SP_HIADDR  = 3'd6,
        SP_RSVD7   = 3'd7
    } space_e;

    typedef struct packed {
        logic [EXP_W-1:0] size_exp;
        logic [3:0]       hold;
        logic [3:0]       setup;
        logic [4:0]       slen;
        logic             wide;
        space_e           space;
        logic             slot_b;
        logic             wprot;
        logic             valid;
    } win_attr_t;

    function automatic logic [EXP_W-1:0] gray_to_bin(input logic [EXP_W-1:0] g);
        logic [EXP_W-1:0] b;
        b[EXP_W-1] = g[EXP_W-1];
        for (int k = EXP_W-2; k >= 0; k--)
            b[k] = b[k+1] ^ g[k];
        return b;
    endfunction

    function automatic win_attr_t unpack_opt(input logic [31:0] o);
        win_attr_t a;
        a.size_exp = gray_to_bin(o[OPT_EX_LO +: EXP_W]);
        a.hold     = o[OPT_HD_LO +: 4];
        a.setup    = o[OPT_SU_LO +: 4];
        a.slen     = o[OPT_LN_LO +: 5];
        a.wide     = o[OPT_WIDE];
        a.space    = space_e'(o[OPT_SP_LO +: 3]);
        a.slot_b   = o[OPT_SLOTB];
        a.wprot    = o[OPT_WP];
        a.valid    = o[OPT_VALID];
        return a;
    endfunction

endpackage

// File: rtl/win_regs.sv
module win_regs
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int IDX_W = $clog2(NWIN)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic                         is_opt,
    input  logic [IDX_W-1:0]             idx,
    input  logic [31:0]                  wdata,
    output logic [NWIN-1:0][ADDR_W-1:0]  base_o,
    output logic [NWIN-1:0][31:0]        opt_o
);

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_o[i] <= '0;
                opt_o[i]  <= '0;
            end else if (we && idx == IDX_W'(i)) begin
                if (is_opt) opt_o[i]  <= wdata;
                else        base_o[i] <= wdata;
            end
        end

        assert_opt_write_R10: assert property (@(posedge clk) disable iff (rst)
            (we && is_opt && idx == IDX_W'(i)) |=> (opt_o[i] == $past(wdata)));
        assert_base_write_R10: assert property (@(posedge clk) disable iff (rst)
            (we && !is_opt && idx == IDX_W'(i)) |=> (base_o[i] == $past(wdata)));
    end

endmodule

// File: rtl/win_match.sv
module win_match
    import win_pkg::*;
#(
    parameter int NWIN = 8
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NWIN-1:0][ADDR_W-1:0]  base_i,
    input  logic [NWIN-1:0][31:0]        opt_i,
    output logic [NWIN-1:0]              hit_o,
    output win_attr_t [NWIN-1:0]         attr_o
);

    for (genvar i = 0; i < NWIN; i++) begin : g_cmp
        logic [ADDR_W-1:0] mask;
        always_comb begin
            attr_o[i] = unpack_opt(opt_i[i]);
            mask      = ~((ADDR_W'(1) << attr_o[i].size_exp) - ADDR_W'(1));
            hit_o[i]  = attr_o[i].valid && ((addr & mask) == (base_i[i] & mask));
        end
    end

endmodule

// File: rtl/win_select.sv
module win_select #(
    parameter int NWIN = 8,
    localparam int IDX_W = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NWIN-1:0]  hits,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = NWIN-1; i >= 0; i--)
            if (hits[i]) idx_o = IDX_W'(i);
        any_o = |hits;
    end

    // the chosen window must hit and no lower window may hit
    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
        any_o |-> (hits[idx_o] && ((hits & ((NWIN'(1) << idx_o) - NWIN'(1))) == '0)));

endmodule

// File: rtl/win_decoder.sv
module win_decoder
    import win_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int IDX_W = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_is_opt,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_req,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_en,
    output logic              rsp_prot_err,
    output logic [IDX_W-1:0]  rsp_win,
    output logic [CARD_W-1:0] rsp_card_addr,
    output logic [2:0]        rsp_space,
    output logic              rsp_wide,
    output logic              rsp_slot_b,
    output logic [3:0]        rsp_setup,
    output logic [4:0]        rsp_len,
    output logic [3:0]        rsp_hold
);

    logic [NWIN-1:0][ADDR_W-1:0] base_w;
    logic [NWIN-1:0][31:0]       opt_w;
    logic [NWIN-1:0]             hits;
    win_attr_t [NWIN-1:0]        attrs;
    logic                        any_hit;
    logic [IDX_W-1:0]            win_idx;
    win_attr_t                   sel;
    logic                        take, perr;

    win_regs #(.NWIN(NWIN)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .is_opt(cfg_is_opt), .idx(cfg_idx),
        .wdata(cfg_wdata), .base_o(base_w), .opt_o(opt_w)
    );

    win_match #(.NWIN(NWIN)) u_match (
        .addr(acc_addr), .base_i(base_w), .opt_i(opt_w), .hit_o(hits), .attr_o(attrs)
    );

    win_select #(.NWIN(NWIN)) u_sel (
        .clk(clk), .rst(rst), .hits(hits), .any_o(any_hit), .idx_o(win_idx)
    );

    always_comb begin
        sel  = attrs[win_idx];
        take = acc_req && any_hit;
        perr = take && acc_wr && sel.wprot;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_miss      <= 1'b0;
            rsp_en        <= 1'b0;
            rsp_prot_err  <= 1'b0;
            rsp_win       <= '0;
            rsp_card_addr <= '0;
            rsp_space     <= '0;
            rsp_wide      <= 1'b0;
            rsp_slot_b    <= 1'b0;
            rsp_setup     <= '0;
            rsp_len       <= '0;
            rsp_hold      <= '0;
        end else begin
            rsp_valid     <= acc_req;
            rsp_hit       <= take;
            rsp_miss      <= acc_req && !any_hit;
            rsp_en        <= take && !perr;
            rsp_prot_err  <= perr;
            rsp_win       <= take ? win_idx : '0;
            rsp_card_addr <= take ? acc_addr[CARD_W-1:0] : '0;
            rsp_space     <= take ? sel.space : '0;
            rsp_wide      <= take && sel.wide;
            rsp_slot_b    <= take && sel.slot_b;
            rsp_setup     <= take ? sel.setup : '0;
            rsp_len       <= take ? sel.slen : '0;
            rsp_hold      <= take ? sel.hold : '0;
        end
    end

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        acc_req |=> rsp_valid);
    assert_no_resp_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !acc_req |=> !rsp_valid);
    assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (!rsp_hit && !rsp_en && !rsp_prot_err && rsp_card_addr == '0));
    assert_prot_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_prot_err |-> (rsp_hit && !rsp_en));
    assert_card_addr_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_req && any_hit) |=> (rsp_card_addr == $past(acc_addr[CARD_W-1:0])));

endmodule

// File: tb/tb_win_decoder.sv
module tb_win_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_is_opt;
    logic [2:0]  cfg_idx;
    logic [31:0] cfg_wdata;
    logic        acc_req, acc_wr;
    logic [31:0] acc_addr;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_en, rsp_prot_err;
    logic [2:0]  rsp_win;
    logic [25:0] rsp_card_addr;
    logic [2:0]  rsp_space;
    logic        rsp_wide, rsp_slot_b;
    logic [3:0]  rsp_setup;
    logic [4:0]  rsp_len;
    logic [3:0]  rsp_hold;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    win_decoder dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_is_opt(cfg_is_opt),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .acc_req(acc_req),
        .acc_wr(acc_wr), .acc_addr(acc_addr), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_en(rsp_en),
        .rsp_prot_err(rsp_prot_err), .rsp_win(rsp_win),
        .rsp_card_addr(rsp_card_addr), .rsp_space(rsp_space),
        .rsp_wide(rsp_wide), .rsp_slot_b(rsp_slot_b), .rsp_setup(rsp_setup),
        .rsp_len(rsp_len), .rsp_hold(rsp_hold)
    );

    // option words, built from the field positions given in R3/R4/R8/R9
    function automatic logic [31:0] mk_opt(input logic [4:0] gcode, input logic [3:0] hd,
            input logic [3:0] su, input logic [4:0] ln, input logic wd,
            input logic [2:0] sp, input logic sb, input logic wp, input logic vl);
        return {gcode, 7'd0, hd, su, ln, wd, sp, sb, wp, vl};
    endfunction

    // expected attributes per window: {space, wide, slot_b, setup, len, hold}
    function automatic logic [17:0] exp_attr(input logic [2:0] w);
        case (w)
            3'd0: return {3'd0, 1'b0, 1'b0, 4'd6, 5'd24, 4'd8};
            3'd1: return {3'd2, 1'b1, 1'b1, 4'd5, 5'd10, 4'd3};
            3'd2: return {3'd3, 1'b0, 1'b0, 4'd4, 5'd8,  4'd2};
            3'd3: return {3'd0, 1'b0, 1'b0, 4'd1, 5'd1,  4'd1};
            3'd7: return {3'd4, 1'b1, 1'b0, 4'd9, 5'd31, 4'd15};
            default: return '0;
        endcase
    endfunction

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        hit;
        logic [2:0]  win;
        logic        prot;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h1000_0010, 1'b0, 1'b1, 3'd0, 1'b0},  // R5 w0 beats overlapping w1
        '{32'h1000_0FFF, 1'b1, 1'b1, 3'd0, 1'b0},  // R3 top byte of 4 KiB
        '{32'h1000_1000, 1'b0, 1'b1, 3'd1, 1'b0},  // R3 just past w0 -> w1
        '{32'h1000_FFFF, 1'b0, 1'b1, 3'd1, 1'b0},  // R3 top of 64 KiB
        '{32'h1001_0000, 1'b0, 1'b0, 3'd0, 1'b0},  // R6 past w1
        '{32'h2000_0305, 1'b0, 1'b1, 3'd2, 1'b0},  // R9 read of protected ok
        '{32'h2000_030F, 1'b1, 1'b1, 3'd2, 1'b1},  // R9 write protected
        '{32'h2000_0310, 1'b1, 1'b0, 3'd0, 1'b0},  // R3 16-byte edge
        '{32'h3000_0000, 1'b0, 1'b1, 3'd3, 1'b0},  // R3 one-byte window
        '{32'h3000_0001, 1'b0, 1'b0, 3'd0, 1'b0},  // R3 one-byte window edge
        '{32'h4000_0000, 1'b0, 1'b0, 3'd0, 1'b0},  // R4 invalid window
        '{32'h0ABC_DEF1, 1'b1, 1'b1, 3'd7, 1'b0},  // R7 large window
        '{32'h07FF_FFFF, 1'b0, 1'b0, 3'd0, 1'b0},  // R6 below w7
        '{32'h0FFF_FFFF, 1'b0, 1'b1, 3'd7, 1'b0}   // R7 top of w7
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] w, input logic o, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_opt = o; cfg_idx = w; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic w);
        @(negedge clk);
        acc_req = 1'b1; acc_wr = w; acc_addr = a;
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic check_resp(input string tag, input vec_t v);
        logic [17:0] ea;
        ea = v.hit ? exp_attr(v.win) : '0;
        chk({tag, " R2 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " R3 hit"}, 32'(rsp_hit), 32'(v.hit));
        chk({tag, " R6 miss"}, 32'(rsp_miss), 32'(!v.hit));
        chk({tag, " R5 win"}, 32'(rsp_win), 32'(v.win));
        chk({tag, " R9 prot"}, 32'(rsp_prot_err), 32'(v.prot));
        chk({tag, " R9 en"}, 32'(rsp_en), 32'(v.hit && !v.prot));
        chk({tag, " R7 card"}, 32'(rsp_card_addr), v.hit ? 32'(v.addr[25:0]) : 32'd0);
        chk({tag, " R8 attr"},
            32'({rsp_space, rsp_wide, rsp_slot_b, rsp_setup, rsp_len, rsp_hold}), 32'(ea));
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        rst = 1'b1; cfg_we = 1'b0; cfg_is_opt = 1'b0; cfg_idx = '0; cfg_wdata = '0;
        acc_req = 1'b0; acc_wr = 1'b0; acc_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 valid", 32'(rsp_valid), 32'd0);
        chk("R1 outputs", 32'({rsp_hit, rsp_miss, rsp_en, rsp_prot_err, rsp_win,
                               rsp_space, rsp_setup}), 32'd0);
        // R1: nothing valid after reset
        access(32'h0000_0000, 1'b0);
        chk("R1 no window valid", 32'(rsp_miss), 32'd1);
        // R2: idle cycle gives no response
        @(negedge clk);
        chk("R2 idle", 32'(rsp_valid), 32'd0);

        // program windows (Gray codes: n0=0, n4=6, n12=10, n16=24, n20=30, n27=22)
        cfg_write(3'd0, 1'b0, 32'h1000_0000);
        cfg_write(3'd0, 1'b1, mk_opt(5'd10, 4'd8, 4'd6, 5'd24, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1));
        cfg_write(3'd1, 1'b0, 32'h1000_0000);
        cfg_write(3'd1, 1'b1, mk_opt(5'd24, 4'd3, 4'd5, 5'd10, 1'b1, 3'd2, 1'b1, 1'b0, 1'b1));
        cfg_write(3'd2, 1'b0, 32'h2000_0300);
        cfg_write(3'd2, 1'b1, mk_opt(5'd6, 4'd2, 4'd4, 5'd8, 1'b0, 3'd3, 1'b0, 1'b1, 1'b1));
        cfg_write(3'd3, 1'b0, 32'h3000_0000);
        cfg_write(3'd3, 1'b1, mk_opt(5'd0, 4'd1, 4'd1, 5'd1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1));
        cfg_write(3'd4, 1'b0, 32'h4000_0000);
        cfg_write(3'd4, 1'b1, mk_opt(5'd30, 4'd7, 4'd7, 5'd7, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0));
        cfg_write(3'd7, 1'b0, 32'h0800_0000);
        cfg_write(3'd7, 1'b1, mk_opt(5'd22, 4'd15, 4'd9, 5'd31, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1));

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].addr, VECS[i].wr);
            check_resp($sformatf("vec%0d", i), VECS[i]);
        end

        // R10: clear w3 valid in the same cycle as an access to it
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_opt = 1'b1; cfg_idx = 3'd3; cfg_wdata = 32'd0;
        acc_req = 1'b1; acc_wr = 1'b0; acc_addr = 32'h3000_0000;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R10 old contents used", 32'({rsp_hit, rsp_win}), 32'({1'b1, 3'd3}));
        @(negedge clk);
        acc_req = 1'b0;
        chk("R10 new contents next cycle", 32'(rsp_miss), 32'd1);

        // R5: make w6 overlap w7; w6 wins
        cfg_write(3'd6, 1'b0, 32'h0ABC_0000);
        cfg_write(3'd6, 1'b1, mk_opt(5'd24, 4'd0, 4'd0, 5'd0, 1'b0, 3'd6, 1'b0, 1'b0, 1'b1));
        access(32'h0ABC_1234, 1'b1);
        chk("R5 w6 over w7", 32'(rsp_win), 32'd6);
        chk("R8 space hiaddr", 32'(rsp_space), 32'd6);

        // R1: reset clears windows
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(32'h1000_0010, 1'b0);
        chk("R1 windows cleared", 32'(rsp_miss), 32'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule